// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers sixteen interrupt sources into one pending register, qualifies them against a mask and a global enable, and offers the most urgent survivor to a processor core. The core receives a request flag, the winning bit index and a vector address, and returns an acknowledge strobe. That strobe retires the pending bit and marks the level as in service. A return strobe later releases the most urgent in-service level.

Four of the sixteen positions belong to core-side sources: a reset request, an emulation request, a power-down request and one general maskable source. The other twelve positions receive peripheral requests through a programmable level table. Each peripheral carries a 4-bit level. Levels 0 to 10 land on positions 4 to 14. Every level of 11 or more folds onto position 15, so those peripherals share one vector. Software can program the mask, force or clear pending bits, program the nesting and global-enable controls, and retarget any peripheral's level. Dedicated enable-all and disable-all strobes override the mask.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the following are all zero: pending, mask, in-service, and control (global enable off, nesting off). Peripheral p holds level p for p < 11 and level 11 otherwise, and irq_o is low.
- R2: A core request on core_req_i[k] sets pending bit k. A peripheral request sets pending bit 4+level when its level is below 11, and bit 15 when the level is 11 to 15, whose vector is 0x01E0.
- R3: Positions 3 to 15 are offered only when both their mask bit and the global enable (control bit 5) are set.
- R4: Positions 0 (reset), 1 (emulation) and 2 (power-down) ignore the mask. Positions 0 and 1 also ignore the global enable. Position 2 is held back while the global enable is clear.
- R5: Among qualified pending bits the lowest index wins. irq_id_o gives that index and vec_o gives VEC_BASE + index*32, with VEC_BASE = 0 by default.
- R6: When ack_i is high while irq_o is high, that edge clears the offered pending bit and sets the same in-service bit. When ack_i is high while irq_o is low, neither register changes.
- R7: With nesting off (control bit 4 clear), nothing except position 0 is offered while any in-service bit is set.
- R8: With nesting on, a candidate other than position 0 is offered only if its index is strictly below the lowest set in-service bit.
- R9: A rti_i pulse clears the lowest-index set in-service bit.
- R10: Write op 1 ORs wr_data_i into pending, and op 2 clears the pending bits set in wr_data_i. A hardware request arriving at the same edge wins over a clear.
- R11: Write op 3 loads control bits 4 and 5 only; all other control bits read 0. dis_int_i clears the global enable and ena_int_i sets it. dis_int_i wins over ena_int_i, and either strobe wins over a control write for bit 5.
- R12: Write op 4 loads wr_data_i[3:0] as the level of peripheral wr_idx_i. An index of NPERIPH or more is ignored. Write op 0 loads the mask. Read selects are 0 mask, 1 pending, 2 control, 3 level of peripheral rd_idx_i, 4 in-service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_req_i | input | NPERIPH | Peripheral request lines |
| core_req_i | input | 4 | Core-side requests (reset, emulation, power-down, general) |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 3 | Write operation code |
| wr_idx_i | input | 4 | Peripheral index for level writes |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 3 | Read select |
| rd_idx_i | input | 4 | Peripheral index for level reads |
| rd_data_o | output | 16 | Read data (combinational) |
| ena_int_i | input | 1 | Enable-all strobe |
| dis_int_i | input | 1 | Disable-all strobe |
| ack_i | input | 1 | Acknowledge from core |
| rti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request offered to core |
| irq_id_o | output | 4 | Offered bit index |
| vec_o | output | VEC_W | Offered vector address |

## Verification
A corrupted level table shows up on the very first request from the affected peripheral. The signature is a wrong irq_id_o and vec_o in the cycle after the request is latched. A stale or wrong in-service bit never fails loudly. Instead it silently withholds lower-priority requests, so the bench reads the in-service register back after every acknowledge and every return, and checks irq_o immediately after each of those strobes. Mask and enable errors show up as irq_o being asserted or missing one cycle after the pending bit is set.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NBITS    = 16;
  localparam int IDX_W    = 4;
  localparam int LVL_W    = 4;
  localparam int CORE_N   = 4;
  localparam int LVL_FOLD = 11;
  localparam int BIT_RST  = 0;
  localparam int BIT_EMU  = 1;
  localparam int BIT_PWR  = 2;
  localparam int CTRL_NEST = 4;
  localparam int CTRL_GEN  = 5;

  typedef enum logic [2:0] {
    OP_MASK = 3'd0, OP_SET = 3'd1, OP_CLR = 3'd2, OP_CTRL = 3'd3, OP_PRIO = 3'd4
  } wr_op_e;

  typedef enum logic [2:0] {
    RD_MASK = 3'd0, RD_LATCH = 3'd1, RD_CTRL = 3'd2, RD_PRIO = 3'd3, RD_ACTIVE = 3'd4
  } rd_sel_e;

  // level -> pending position; high levels fold onto the last position
  function automatic logic [IDX_W-1:0] level_to_bit(input logic [LVL_W-1:0] lvl);
    if (int'(lvl) >= LVL_FOLD) return IDX_W'(NBITS - 1);
    return IDX_W'(CORE_N) + IDX_W'(lvl);
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(input logic [NBITS-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NBITS - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [NBITS-1:0] onehot(input logic [IDX_W-1:0] i);
    return NBITS'(1) << i;
  endfunction

  function automatic logic [31:0] vec_offset(input logic [IDX_W-1:0] i, input int shift);
    return 32'(i) << shift;
  endfunction
endpackage

// File: rtl/irq_prio_map.sv
module irq_prio_map
  import irq_prio_pkg::*;
#(
  parameter int NPERIPH = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [LVL_W-1:0]   wr_lvl,
  input  logic [NPERIPH-1:0] periph_req,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [NBITS-1:0]   hit_bits,
  output logic [LVL_W-1:0]   rd_lvl
);
  logic [LVL_W-1:0] lvl_arr [NPERIPH];

  for (genvar p = 0; p < NPERIPH; p++) begin : g_per
    localparam logic [LVL_W-1:0] RST_LVL = (p >= LVL_FOLD) ? LVL_W'(LVL_FOLD) : LVL_W'(p);
    logic [LVL_W-1:0] lvl_q;

    always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= RST_LVL;
      else if (wr_en && wr_idx == IDX_W'(p)) lvl_q <= wr_lvl;
    end
    assign lvl_arr[p] = lvl_q;

    // folded levels always reach the shared last position
    p_fold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (periph_req[p] && int'(lvl_q) >= LVL_FOLD) |-> hit_bits[NBITS-1]);
  end

  always_comb begin
    hit_bits = '0;
    for (int p = 0; p < NPERIPH; p++) begin
      if (periph_req[p]) hit_bits[level_to_bit(lvl_arr[p])] = 1'b1;
    end
  end

  always_comb begin
    rd_lvl = '0;
    for (int p = 0; p < NPERIPH; p++) begin
      if (rd_idx == IDX_W'(p)) rd_lvl = lvl_arr[p];
    end
  end
endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] hw_set,
  input  logic             sw_set_en,
  input  logic             sw_clr_en,
  input  logic [NBITS-1:0] sw_data,
  input  logic             ack_en,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [NBITS-1:0] latch_q
);
  logic [NBITS-1:0] set_vec, clr_vec;

  assign set_vec = hw_set | (sw_set_en ? sw_data : '0);
  assign clr_vec = (sw_clr_en ? sw_data : '0) | (ack_en ? onehot(ack_idx) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= (latch_q & ~clr_vec) | set_vec;
  end

  p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !set_vec[ack_idx]) |=> !latch_q[$past(ack_idx)]);

  p_sw_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_en |=> ((latch_q & $past(sw_data)) == $past(sw_data)));

  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((latch_q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/irq_active.sv
module irq_active
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop_en,
  output logic [NBITS-1:0] act_q
);
  logic [IDX_W-1:0] pop_idx;
  logic [NBITS-1:0] pop_vec, push_vec;

  assign pop_idx  = lowest_set(act_q);
  assign pop_vec  = (pop_en && act_q != '0) ? onehot(pop_idx) : '0;
  assign push_vec = push_en ? onehot(push_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= (act_q & ~pop_vec) | push_vec;
  end

  p_push_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |=> act_q[$past(push_idx)]);

  p_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && !push_en && act_q != '0) |=> !act_q[$past(pop_idx)]);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] latch,
  input  logic [NBITS-1:0] mask,
  input  logic             glob_en,
  input  logic             nest_en,
  input  logic [NBITS-1:0] act,
  output logic             irq,
  output logic [IDX_W-1:0] irq_idx
);
  localparam logic [NBITS-1:0] NOMASK = NBITS'((1 << BIT_RST) | (1 << BIT_EMU) | (1 << BIT_PWR));
  localparam logic [NBITS-1:0] NOGATE = NBITS'((1 << BIT_RST) | (1 << BIT_EMU));

  logic [NBITS-1:0] qual, gate;
  logic [IDX_W-1:0] cand, ceil_idx;
  logic             cand_v, act_any, allowed;

  assign gate     = glob_en ? {NBITS{1'b1}} : NOGATE;
  assign qual     = latch & (mask | NOMASK) & gate;
  assign cand     = lowest_set(qual);
  assign cand_v   = |qual;
  assign ceil_idx = lowest_set(act);
  assign act_any  = |act;
  assign allowed  = !act_any || (cand == IDX_W'(BIT_RST)) || (nest_en && cand < ceil_idx);
  assign irq      = cand_v && allowed;
  assign irq_idx  = irq ? cand : '0;

  p_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> latch[irq_idx]);

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && int'(irq_idx) > BIT_PWR) |-> (mask[irq_idx] && glob_en));

  p_pwr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_idx == IDX_W'(BIT_PWR)) |-> glob_en);

  p_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !nest_en && irq_idx != IDX_W'(BIT_RST)) |-> (act == '0));

  p_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && nest_en && act != '0 && irq_idx != IDX_W'(BIT_RST)) |-> (irq_idx < lowest_set(act)));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NPERIPH   = 15,
  parameter int VEC_W     = 16,
  parameter int VEC_SHIFT = 5,
  parameter logic [VEC_W-1:0] VEC_BASE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPERIPH-1:0] periph_req_i,
  input  logic [CORE_N-1:0]  core_req_i,
  input  logic               wr_en_i,
  input  logic [2:0]         wr_op_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [NBITS-1:0]   wr_data_i,
  input  logic [2:0]         rd_sel_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [NBITS-1:0]   rd_data_o,
  input  logic               ena_int_i,
  input  logic               dis_int_i,
  input  logic               ack_i,
  input  logic               rti_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   irq_id_o,
  output logic [VEC_W-1:0]   vec_o
);
  wr_op_e  op;
  rd_sel_e rsel;
  assign op   = wr_op_e'(wr_op_i);
  assign rsel = rd_sel_e'(rd_sel_i);

  logic [NBITS-1:0] mask_q, latch_q, act_q, hit_bits, hw_set;
  logic             gen_q, nest_q;
  logic [LVL_W-1:0] rd_lvl;
  logic             irq, ack_fire;
  logic [IDX_W-1:0] irq_idx;

  // mask and control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      gen_q  <= 1'b0;
      nest_q <= 1'b0;
    end else begin
      if (wr_en_i && op == OP_MASK) mask_q <= wr_data_i;
      if (wr_en_i && op == OP_CTRL) nest_q <= wr_data_i[CTRL_NEST];
      if (dis_int_i)                gen_q  <= 1'b0;
      else if (ena_int_i)           gen_q  <= 1'b1;
      else if (wr_en_i && op == OP_CTRL) gen_q <= wr_data_i[CTRL_GEN];
    end
  end

  p_dis_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dis_int_i |=> !gen_q);
  p_ena_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_int_i && !dis_int_i) |=> gen_q);

  irq_prio_map #(.NPERIPH(NPERIPH)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en_i && op == OP_PRIO),
    .wr_idx     (wr_idx_i),
    .wr_lvl     (wr_data_i[LVL_W-1:0]),
    .periph_req (periph_req_i),
    .rd_idx     (rd_idx_i),
    .hit_bits   (hit_bits),
    .rd_lvl     (rd_lvl)
  );

  assign hw_set   = hit_bits | NBITS'(core_req_i);
  assign ack_fire = ack_i && irq;

  irq_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_set    (hw_set),
    .sw_set_en (wr_en_i && op == OP_SET),
    .sw_clr_en (wr_en_i && op == OP_CLR),
    .sw_data   (wr_data_i),
    .ack_en    (ack_fire),
    .ack_idx   (irq_idx),
    .latch_q   (latch_q)
  );

  irq_active u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_en  (ack_fire),
    .push_idx (irq_idx),
    .pop_en   (rti_i),
    .act_q    (act_q)
  );

  irq_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .latch   (latch_q),
    .mask    (mask_q),
    .glob_en (gen_q),
    .nest_en (nest_q),
    .act     (act_q),
    .irq     (irq),
    .irq_idx (irq_idx)
  );

  p_ack_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq && !rti_i) |=> $stable(act_q));

  assign irq_o    = irq;
  assign irq_id_o = irq_idx;
  assign vec_o    = irq ? VEC_W'(32'(VEC_BASE) + vec_offset(irq_idx, VEC_SHIFT)) : '0;

  always_comb begin
    unique case (rsel)
      RD_MASK:   rd_data_o = mask_q;
      RD_LATCH:  rd_data_o = latch_q;
      RD_CTRL:   rd_data_o = (NBITS'(nest_q) << CTRL_NEST) | (NBITS'(gen_q) << CTRL_GEN);
      RD_PRIO:   rd_data_o = NBITS'(rd_lvl);
      RD_ACTIVE: rd_data_o = act_q;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int NP = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NP-1:0] periph_req = '0;
  logic [3:0]  core_req = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_op = '0;
  logic [3:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [3:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        ena_int = 1'b0, dis_int = 1'b0, ack = 1'b0, rti = 1'b0;
  logic        irq;
  logic [3:0]  irq_id;
  logic [15:0] vec;

  int nvec = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.NPERIPH(NP)) dut (
    .clk(clk), .rst_n(rst_n), .periph_req_i(periph_req), .core_req_i(core_req),
    .wr_en_i(wr_en), .wr_op_i(wr_op), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .ena_int_i(ena_int), .dis_int_i(dis_int), .ack_i(ack), .rti_i(rti),
    .irq_o(irq), .irq_id_o(irq_id), .vec_o(vec)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] op, input logic [3:0] idx, input logic [15:0] d);
    wr_en = 1'b1; wr_op = op; wr_idx = idx; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [3:0] i, output logic [15:0] d);
    rd_sel = s; rd_idx = i;
    #1;
    d = rd_data;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulse_rti();
    rti = 1'b1; tick(); rti = 1'b0;
  endtask

  function automatic int fold_bit(input int lvl);
    return (lvl >= 11) ? 15 : 4 + lvl;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(0, 0, d); chk("R1 mask", d, 0);
    rd(1, 0, d); chk("R1 latch", d, 0);
    rd(2, 0, d); chk("R1 ctrl", d, 0);
    rd(4, 0, d); chk("R1 active", d, 0);
    for (int p = 0; p < NP; p++) begin
      rd(3, 4'(p), d); chk("R1 level", d, (p < 11) ? p : 11);
    end

    // R2/R5/R6/R9/R12 sweep of every peripheral and level
    wr(3, 0, 16'h0020);
    wr(0, 0, 16'hFFFF);
    for (int p = 0; p < NP; p++) begin
      for (int l = 0; l < 16; l++) begin
        int eb;
        eb = fold_bit(l);
        wr(4, 4'(p), 16'(l));
        rd(3, 4'(p), d); chk("R12 level write", d, l);
        periph_req[p] = 1'b1; tick(); periph_req[p] = 1'b0;
        chk("R2 irq", irq, 1);
        chk("R2 id", irq_id, eb);
        chk("R5 vec", vec, eb * 32);
        pulse_ack();
        rd(1, 0, d); chk("R6 latch cleared", d, 0);
        rd(4, 0, d); chk("R6 active set", d, 1 << eb);
        pulse_rti();
        rd(4, 0, d); chk("R9 active popped", d, 0);
      end
    end
    for (int p = 0; p < NP; p++) wr(4, 4'(p), 16'((p < 11) ? p : 11));
    wr(4, 4'd15, 16'h0003);
    for (int p = 0; p < NP; p++) begin
      rd(3, 4'(p), d); chk("R12 out-of-range ignored", d, (p < 11) ? p : 11);
    end

    // R2 core request lines
    for (int k = 0; k < 4; k++) begin
      core_req[k] = 1'b1; tick(); core_req[k] = 1'b0;
      rd(1, 0, d); chk("R2 core line", d, 1 << k);
      wr(2, 0, 16'hFFFF);
    end

    // R3 mask and global enable on maskable positions
    for (int b = 3; b < 16; b++) begin
      wr(0, 0, 16'h0000);
      wr(1, 0, 16'(1 << b));
      chk("R3 masked", irq, 0);
      rd(1, 0, d); chk("R10 forced", d, 1 << b);
      wr(0, 0, 16'(1 << b));
      chk("R3 unmasked", irq, 1);
      chk("R3 id", irq_id, b);
      wr(3, 0, 16'h0000);
      chk("R3 global off", irq, 0);
      wr(3, 0, 16'h0020);
      chk("R3 global on", irq, 1);
      wr(2, 0, 16'(1 << b));
      chk("R10 cleared irq", irq, 0);
      rd(1, 0, d); chk("R10 cleared latch", d, 0);
    end

    // R4 nonmaskable positions
    wr(0, 0, 16'h0000);
    wr(3, 0, 16'h0000);
    wr(1, 0, 16'h0001); chk("R4 reset irq", irq, 1); chk("R4 reset id", irq_id, 0);
    wr(2, 0, 16'h0001);
    wr(1, 0, 16'h0002); chk("R4 emu irq", irq, 1); chk("R4 emu id", irq_id, 1);
    wr(2, 0, 16'h0002);
    wr(1, 0, 16'h0004); chk("R4 pwr blocked", irq, 0);
    wr(3, 0, 16'h0020); chk("R4 pwr enabled", irq, 1); chk("R4 pwr id", irq_id, 2);
    wr(2, 0, 16'h0004);

    // R5 every pair of positions
    wr(0, 0, 16'hFFFF);
    for (int a = 0; a < 16; a++) begin
      for (int b = a + 1; b < 16; b++) begin
        wr(1, 0, 16'((1 << a) | (1 << b)));
        chk("R5 pair id", irq_id, a);
        chk("R5 pair vec", vec, a * 32);
        wr(2, 0, 16'hFFFF);
      end
    end

    // R7 sequential servicing
    wr(1, 0, 16'h0400); pulse_ack();
    rd(4, 0, d); chk("R7 active", d, 16'h0400);
    wr(1, 0, 16'h0020); chk("R7 blocked", irq, 0);
    wr(1, 0, 16'h0001); chk("R7 reset passes", irq, 1); chk("R7 reset id", irq_id, 0);
    wr(2, 0, 16'h0001); chk("R7 blocked again", irq, 0);
    pulse_rti(); chk("R7 after return", irq, 1); chk("R7 id", irq_id, 5);
    pulse_ack(); pulse_rti();
    rd(4, 0, d); chk("R7 active empty", d, 0);

    // R8/R9 nesting
    wr(3, 0, 16'h0030);
    wr(1, 0, 16'h0400); pulse_ack();
    wr(1, 0, 16'h1000); chk("R8 lower blocked", irq, 0);
    wr(1, 0, 16'h0100); chk("R8 higher preempts", irq, 1); chk("R8 id", irq_id, 8);
    pulse_ack();
    rd(4, 0, d); chk("R8 two active", d, 16'h0500);
    wr(1, 0, 16'h0200); chk("R8 equal-or-lower blocked", irq, 0);
    pulse_rti();
    rd(4, 0, d); chk("R9 pop lowest", d, 16'h0400);
    chk("R8 now 9", irq_id, 9); chk("R8 irq 9", irq, 1);
    pulse_ack(); pulse_rti();
    chk("R8 12 still blocked", irq, 0);
    pulse_rti();
    rd(4, 0, d); chk("R9 empty", d, 0);
    chk("R8 12 offered", irq_id, 12);
    pulse_ack(); pulse_rti();

    // R6 acknowledge without a request is ignored
    wr(0, 0, 16'h0000);
    wr(1, 0, 16'h0020);
    chk("R6 idle irq", irq, 0);
    pulse_ack();
    rd(1, 0, d); chk("R6 idle latch kept", d, 16'h0020);
    rd(4, 0, d); chk("R6 idle active kept", d, 0);
    wr(2, 0, 16'hFFFF);

    // R10 hardware request wins over a clear
    wr_en = 1'b1; wr_op = 3'd2; wr_data = 16'h0080; periph_req[3] = 1'b1;
    tick();
    wr_en = 1'b0; periph_req[3] = 1'b0;
    rd(1, 0, d); chk("R10 hw beats clear", d, 16'h0080);
    wr(2, 0, 16'hFFFF);

    // R11 control register and strobes
    wr(3, 0, 16'hFFFF); rd(2, 0, d); chk("R11 ctrl bits", d, 16'h0030);
    dis_int = 1'b1; tick(); dis_int = 1'b0;
    rd(2, 0, d); chk("R11 disable", d, 16'h0010);
    ena_int = 1'b1; tick(); ena_int = 1'b0;
    rd(2, 0, d); chk("R11 enable", d, 16'h0030);
    ena_int = 1'b1; dis_int = 1'b1; tick(); ena_int = 1'b0; dis_int = 1'b0;
    rd(2, 0, d); chk("R11 disable wins", d, 16'h0010);
    wr_en = 1'b1; wr_op = 3'd3; wr_data = 16'h0000; ena_int = 1'b1;
    tick();
    wr_en = 1'b0; ena_int = 1'b0;
    rd(2, 0, d); chk("R11 strobe beats write", d, 16'h0020);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule